// File: doc/BRIEF.md
# Two-Bank Interleaved Asynchronous SRAM Controller

The block connects a synchronous 32-bit processor bus to two asynchronous SRAM banks. Each word is placed in a bank chosen by the lowest bit of its word address. The remaining address bits select the row inside that bank. The words of a burst therefore alternate between the banks. Each SRAM access takes two bus cycles, yet the bus still moves one word per cycle, because one bank is in its setup cycle while the other is in its strobe cycle.

The bus master opens a cycle with a one-cycle start pulse that carries the word address, the direction and a length code. It then transfers one beat on every clock edge at which the ready output is high. The master can insert any number of wait cycles at any beat. A wait freezes the whole controller, and it continues afterwards from the point where it stopped. Bursts may start on an even or an odd word. The word address counts up linearly across page boundaries and wraps at the top of the address space.

Top module: `ilv_sram_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every bank has chip select, write enable and output enable high (inactive) and its data driver off. Ready and the bus read-data driver enable are low during reset.
- R2: A word at word address w is stored in bank w[0] at row w[AW-1:1]. Successive words of a burst are issued to alternating banks, and exactly one bank receives each issue.
- R3: A write to a bank occupies a setup cycle and then a strobe cycle. In the setup cycle chip select is low, write enable is high, and address and data are driven. In the strobe cycle write enable is low. Address, data and the data driver are unchanged for every cycle that write enable stays low, and output enable stays high.
- R4: A read from a bank occupies a setup cycle, with chip select low and output enable high, and then a cycle with output enable low and the address unchanged. The bank data driver stays off. The word is captured at the end of the output-enable cycle.
- R5: Number the start-pulse cycle 0, with no wait cycles. Write beat k is accepted at the end of cycle 1+k. Read beat k is presented with ready high in cycle 4+k. Every wait cycle delays all later beats by exactly one cycle.
- R6: The length code n on bus_len gives a burst of n+1 words. The words are at consecutive addresses counted modulo 2^AW, one per cycle with no gaps when there are no waits. This holds from any start parity and across any page boundary, including a boundary at the final beat. Read beats return exactly the stored words.
- R7: While bus_wait is high, ready is low and no beat transfers. Every bank output holds the value it had in the cycle before. The burst resumes exactly at the interrupted beat.
- R8: Write enable and output enable of one bank are never low together, and a bank's data driver is on only during write accesses.
- R9: bus_rdata_oe is high only while read data is being held for the bus. It is low during write bursts and while idle, and no bank drives its data pins while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | One-cycle pulse that opens a cycle while idle |
| bus_wr | input | 1 | Direction of the opened cycle: 1 write, 0 read |
| bus_addr | input | AW | Word address of the first beat |
| bus_len | input | LW | Length code; the burst has bus_len+1 words |
| bus_wait | input | 1 | Processor wait cycle; freezes the controller |
| bus_wdata | input | DW | Write data of the current beat |
| bus_rdy | output | 1 | High in a cycle whose closing edge transfers a beat |
| bus_rdata | output | DW | Read data of the current beat |
| bus_rdata_oe | output | 1 | Enable for the bus-side read-data driver |
| mem_cs_n | output | 2 | Chip select per bank, active low |
| mem_we_n | output | 2 | Write enable per bank, active low |
| mem_oe_n | output | 2 | Output enable per bank, active low |
| mem_addr | output | 2 x (AW-1) | Row address per bank |
| mem_dq_o | output | 2 x DW | Outgoing data per bank |
| mem_dq_oe | output | 2 | Data pin driver enable per bank |
| mem_dq_i | input | 2 x DW | Incoming data per bank |

## Verification
A processor wait cycle can land in the same cycle as a bank's write strobe or read output-enable cycle. The freeze must then stretch that strobe without moving the address, the data or the beat count. The bench provokes this by sweeping the beat at which the wait is inserted, and the wait length, over every start address of a small configuration, so that waits fall on strobes of both banks and on the initial latency. The outcome is judged three ways: ready must stay low, the bank outputs must match those of the previous cycle, and each beat must arrive exactly one cycle later per wait. Readback then confirms that no stretched write corrupted a word.

// File: rtl/ilv_sram_pkg.sv
package ilv_sram_pkg;

  // Life cycle of one access inside one bank.
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2
  } bank_ph_e;

  // Bank that holds a word: lowest word-address bit.
  function automatic logic bank_of(input logic [31:0] wa);
    return wa[0];
  endfunction

  // Row inside the bank: the word address without its bank bit.
  function automatic logic [31:0] row_of(input logic [31:0] wa);
    return wa >> 1;
  endfunction

  // Next word address of a burst, wrapping modulo 2^aw.
  function automatic logic [31:0] step_word(input logic [31:0] wa, input int unsigned aw);
    logic [31:0] mask;
    mask = (aw >= 32) ? 32'hFFFF_FFFF : ((32'd1 << aw) - 32'd1);
    return (wa + 32'd1) & mask;
  endfunction

endpackage

// File: rtl/ilv_burst_seq.sv
module ilv_burst_seq
  import ilv_sram_pkg::*;
#(
  parameter int AW = 12,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          start,
  input  logic          start_wr,
  input  logic [AW-1:0] start_addr,
  input  logic [LW-1:0] start_len,
  output logic          active,
  output logic          is_wr,
  output logic          issue,
  output logic [AW-1:0] issue_addr
);

  logic [AW-1:0] ptr_q;
  logic [LW-1:0] left_q;

  assign issue      = active & adv;
  assign issue_addr = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      is_wr  <= 1'b0;
      ptr_q  <= '0;
      left_q <= '0;
    end else if (adv) begin
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          is_wr  <= start_wr;
          ptr_q  <= start_addr;
          left_q <= start_len;
        end
      end else begin
        ptr_q <= AW'(step_word(32'(ptr_q), AW));
        if (left_q == '0) active <= 1'b0;
        else              left_q <= left_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/ilv_bank_port.sv
module ilv_bank_port
  import ilv_sram_pkg::*;
#(
  parameter int RW = 11,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          sel,
  input  logic          sel_wr,
  input  logic [RW-1:0] sel_row,
  input  logic [DW-1:0] sel_data,
  output logic          cs_n,
  output logic          we_n,
  output logic          oe_n,
  output logic [RW-1:0] addr,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe,
  output logic          rd_done
);

  bank_ph_e ph_q;
  logic     wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
      wr_q <= 1'b0;
      addr <= '0;
      dq_o <= '0;
    end else if (adv) begin
      if (sel) begin
        ph_q <= PH_SETUP;
        wr_q <= sel_wr;
        addr <= sel_row;
        if (sel_wr) dq_o <= sel_data;
      end else begin
        case (ph_q)
          PH_SETUP:  ph_q <= PH_STROBE;
          default:   ph_q <= PH_IDLE;
        endcase
      end
    end
  end

  assign cs_n    = (ph_q == PH_IDLE);
  assign we_n    = !((ph_q == PH_STROBE) && wr_q);
  assign oe_n    = !((ph_q == PH_STROBE) && !wr_q);
  assign dq_oe   = (ph_q != PH_IDLE) && wr_q;
  // A read strobe ends at the next advancing edge: capture point.
  assign rd_done = (ph_q == PH_STROBE) && !wr_q;

endmodule

// File: rtl/ilv_rd_capture.sv
module ilv_rd_capture #(
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic [1:0]           rd_done,
  input  logic [1:0][DW-1:0]   dq_i,
  output logic                 rvalid,
  output logic [DW-1:0]        rdata
);

  logic [DW-1:0] pick;

  always_comb begin
    pick = dq_i[0];
    if (rd_done[1]) pick = dq_i[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else if (adv) begin
      rvalid <= |rd_done;
      if (|rd_done) rdata <= pick;
    end
  end

endmodule

// File: rtl/ilv_sram_ctrl.sv
module ilv_sram_ctrl
  import ilv_sram_pkg::*;
#(
  parameter int AW = 12,
  parameter int LW = 4,
  parameter int DW = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_start,
  input  logic                    bus_wr,
  input  logic [AW-1:0]           bus_addr,
  input  logic [LW-1:0]           bus_len,
  input  logic                    bus_wait,
  input  logic [DW-1:0]           bus_wdata,
  output logic                    bus_rdy,
  output logic [DW-1:0]           bus_rdata,
  output logic                    bus_rdata_oe,
  output logic [1:0]              mem_cs_n,
  output logic [1:0]              mem_we_n,
  output logic [1:0]              mem_oe_n,
  output logic [1:0][AW-2:0]      mem_addr,
  output logic [1:0][DW-1:0]      mem_dq_o,
  output logic [1:0]              mem_dq_oe,
  input  logic [1:0][DW-1:0]      mem_dq_i
);

  localparam int RW = AW - 1;

  logic          adv;
  logic          seq_active;
  logic          seq_wr;
  logic          seq_issue;
  logic [AW-1:0] seq_addr;
  logic [1:0]    issue_vec;
  logic [1:0]    rd_done;
  logic          rvalid;
  logic [RW-1:0] issue_row;

  // A processor wait freezes every register of the block.
  assign adv       = !bus_wait;
  assign issue_row = RW'(row_of(32'(seq_addr)));

  ilv_burst_seq #(.AW(AW), .LW(LW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv        (adv),
    .start      (bus_start),
    .start_wr   (bus_wr),
    .start_addr (bus_addr),
    .start_len  (bus_len),
    .active     (seq_active),
    .is_wr      (seq_wr),
    .issue      (seq_issue),
    .issue_addr (seq_addr)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    assign issue_vec[b] = seq_issue && (bank_of(32'(seq_addr)) == 1'(b));

    ilv_bank_port #(.RW(RW), .DW(DW)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (adv),
      .sel      (issue_vec[b]),
      .sel_wr   (seq_wr),
      .sel_row  (issue_row),
      .sel_data (bus_wdata),
      .cs_n     (mem_cs_n[b]),
      .we_n     (mem_we_n[b]),
      .oe_n     (mem_oe_n[b]),
      .addr     (mem_addr[b]),
      .dq_o     (mem_dq_o[b]),
      .dq_oe    (mem_dq_oe[b]),
      .rd_done  (rd_done[b])
    );
  end

  ilv_rd_capture #(.DW(DW)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv),
    .rd_done (rd_done),
    .dq_i    (mem_dq_i),
    .rvalid  (rvalid),
    .rdata   (bus_rdata)
  );

  assign bus_rdata_oe = rvalid;
  assign bus_rdy      = adv && (rvalid || (seq_active && seq_wr));

endmodule

// File: rtl/ilv_sram_chk.sv
module ilv_sram_chk #(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wait,
  input logic               bus_rdata_oe,
  input logic [1:0]         mem_cs_n,
  input logic [1:0]         mem_we_n,
  input logic [1:0]         mem_oe_n,
  input logic [1:0][AW-2:0] mem_addr,
  input logic [1:0][DW-1:0] mem_dq_o,
  input logic [1:0]         mem_dq_oe,
  input logic               issue,
  input logic [AW-1:0]      issue_addr,
  input logic [1:0]         issue_vec
);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (mem_cs_n == 2'b11 && mem_we_n == 2'b11 && mem_oe_n == 2'b11 && mem_dq_oe == 2'b00));

  // R2
  one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(issue_vec) && (!issue || $countones(issue_vec) == 1));

  // R2
  alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue && $past(issue) |-> issue_vec != $past(issue_vec));

  // R6
  linear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue && $past(issue) |-> issue_addr == AW'($past(issue_addr) + AW'(1)));

  // R9
  rdoe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata_oe |-> mem_dq_oe == 2'b00);

  for (genvar b = 0; b < 2; b++) begin : g_bk
    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_we_n[b] && !mem_oe_n[b]));

    // R3
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n[b] |-> !$past(mem_cs_n[b]) && $stable(mem_addr[b]) &&
                       $stable(mem_dq_o[b]) && mem_dq_oe[b] && mem_oe_n[b]);

    // R4
    rd_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n[b] |-> !$past(mem_cs_n[b]) && $stable(mem_addr[b]) && !mem_dq_oe[b]);

    // R7
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_wait) |-> $stable(mem_cs_n[b]) && $stable(mem_we_n[b]) &&
                          $stable(mem_oe_n[b]) && $stable(mem_addr[b]) &&
                          $stable(mem_dq_o[b]) && $stable(mem_dq_oe[b]));
  end

endmodule

bind ilv_sram_ctrl ilv_sram_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_wait     (bus_wait),
  .bus_rdata_oe (bus_rdata_oe),
  .mem_cs_n     (mem_cs_n),
  .mem_we_n     (mem_we_n),
  .mem_oe_n     (mem_oe_n),
  .mem_addr     (mem_addr),
  .mem_dq_o     (mem_dq_o),
  .mem_dq_oe    (mem_dq_oe),
  .issue        (seq_issue),
  .issue_addr   (seq_addr),
  .issue_vec    (issue_vec)
);

// File: tb/tb_ilv_sram_ctrl.sv
module tb_ilv_sram_ctrl;

  localparam int AW = 6;
  localparam int LW = 3;
  localparam int DW = 32;
  localparam int RW = AW - 1;
  localparam int NW = 1 << AW;
  localparam int NR = 1 << RW;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 bus_start, bus_wr, bus_wait;
  logic [AW-1:0]        bus_addr;
  logic [LW-1:0]        bus_len;
  logic [DW-1:0]        bus_wdata;
  logic                 bus_rdy, bus_rdata_oe;
  logic [DW-1:0]        bus_rdata;
  logic [1:0]           mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [1:0][RW-1:0]   mem_addr;
  logic [1:0][DW-1:0]   mem_dq_o, mem_dq_i;

  int nchk = 0, nerr = 0;
  int mchk = 0, merr = 0;
  int wd_cyc = 0;
  bit wd_hit = 1'b0;
  logic [DW-1:0] expw [NW];
  logic [DW-1:0] mem [2][NR];

  always #5 clk = ~clk;

  ilv_sram_ctrl #(.AW(AW), .LW(LW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_len(bus_len), .bus_wait(bus_wait),
    .bus_wdata(bus_wdata), .bus_rdy(bus_rdy), .bus_rdata(bus_rdata),
    .bus_rdata_oe(bus_rdata_oe), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  function automatic logic [DW-1:0] pre(input int w);
    return 32'h1000_0000 + 32'(w) * 32'h0001_0003;
  endfunction

  function automatic logic [DW-1:0] wpat(input int tagv, input int beat);
    return 32'hA000_0005 ^ (32'(tagv) << 12) ^ (32'(beat) << 4);
  endfunction

  // Asynchronous SRAM bank models, both banks read combinationally.
  for (genvar gb = 0; gb < 2; gb++) begin : g_mdl
    assign mem_dq_i[gb] = (!mem_cs_n[gb] && !mem_oe_n[gb]) ? mem[gb][mem_addr[gb]] : 32'hDEAD_0000;
  end

  logic [1:0]         pw_low;
  logic [1:0][RW-1:0] paddr;
  logic [1:0][DW-1:0] pdat;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int r = 0; r < NR; r++) mem[b][r] = pre(2 * r + b);
      pw_low = 2'b00;
    end else begin
      for (int b = 0; b < 2; b++) begin
        if (!mem_we_n[b] || !mem_oe_n[b]) begin
          mchk++;
          if (!mem_we_n[b] && !mem_oe_n[b]) begin
            merr++;
            $display("FAIL R8 bank %0d strobes actual we_n=0 oe_n=0 expected one high", b);
          end
        end
        if (!mem_oe_n[b] && mem_dq_oe[b]) begin
          merr++;
          $display("FAIL R8 bank %0d drives on read actual=1 expected=0", b);
        end
        if (!mem_we_n[b]) begin
          mchk++;
          if (mem_cs_n[b] || !mem_dq_oe[b]) begin
            merr++;
            $display("FAIL R3 bank %0d write pulse actual cs_n=%0d dq_oe=%0d expected 0/1",
                     b, mem_cs_n[b], mem_dq_oe[b]);
          end
          if (pw_low[b] && (mem_addr[b] != paddr[b] || mem_dq_o[b] != pdat[b])) begin
            merr++;
            $display("FAIL R3 bank %0d moved during pulse actual=%0h/%0h expected=%0h/%0h",
                     b, mem_addr[b], mem_dq_o[b], paddr[b], pdat[b]);
          end
          mem[b][mem_addr[b]] = mem_dq_o[b];
        end
        pw_low[b] = !mem_we_n[b];
        paddr[b]  = mem_addr[b];
        pdat[b]   = mem_dq_o[b];
      end
    end
  end

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors",
             nchk + mchk + int'(wd_hit), nerr + merr + int'(wd_hit));
  endtask

  always @(posedge clk) begin
    wd_cyc++;
    if (wd_cyc > 150000 && !wd_hit) begin
      wd_hit = 1'b1;
      $display("FAIL R7 watchdog actual=%0d cycles expected below 150000", wd_cyc);
      summary();
      $finish;
    end
  end

  // One bus cycle; a wait of wn cycles is inserted before beat wbeat.
  task automatic burst(input int a, input int len, input bit wr,
                       input int wbeat, input int wn, input int tagv);
    int beat, cyc, waited, guard, wa, base;
    bit prev_wait;
    logic [63:0] snap, prev_snap;
    logic [DW-1:0] d;
    @(negedge clk);
    bus_start = 1'b1; bus_wr = wr; bus_addr = AW'(a); bus_len = LW'(len); bus_wait = 1'b0;
    beat = 0; cyc = 0; waited = 0; guard = 0; prev_wait = 1'b0; prev_snap = '0;
    base = wr ? 1 : 4;
    while (beat <= len) begin
      @(negedge clk);
      bus_start = 1'b0;
      cyc++; guard++;
      wa = (a + beat) % NW;
      d  = wpat(tagv, beat);
      bus_wdata = d;
      if (beat == wbeat && waited < wn) begin bus_wait = 1'b1; waited++; end
      else bus_wait = 1'b0;
      #1;
      snap = {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, 16'(mem_addr), 32'(mem_dq_o[0] ^ mem_dq_o[1])};
      if (prev_wait) check(snap == prev_snap, "R7 bank outputs held across wait", snap, prev_snap);
      if (bus_wait) begin
        check(!bus_rdy, "R7 ready low in wait cycle", 64'(bus_rdy), 0);
      end else if (bus_rdy) begin
        check(cyc == base + beat + waited, "R5 beat cycle", 64'(cyc), 64'(base + beat + waited));
        if (wr) begin
          check(!bus_rdata_oe, "R9 read driver off in write", 64'(bus_rdata_oe), 0);
          expw[wa] = d;
        end else begin
          check(bus_rdata == expw[wa], "R6 read word", 64'(bus_rdata), 64'(expw[wa]));
          check(bus_rdata_oe, "R9 read driver on with data", 64'(bus_rdata_oe), 1);
        end
        beat++;
      end
      prev_wait = bus_wait;
      prev_snap = snap;
      if (guard > 64) begin
        nchk++; nerr++;
        $display("FAIL R7 burst stalled actual=%0d beats expected=%0d", beat, len + 1);
        break;
      end
    end
    bus_wait = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    bus_start = 1'b0; bus_wr = 1'b0; bus_wait = 1'b0;
    bus_addr = '0; bus_len = '0; bus_wdata = '0;
    for (int w = 0; w < NW; w++) expw[w] = pre(w);
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check(mem_cs_n == 2'b11, "R1 chip selects idle", 64'(mem_cs_n), 3);
    check(mem_we_n == 2'b11 && mem_oe_n == 2'b11, "R1 strobes idle", 64'({mem_we_n, mem_oe_n}), 15);
    check(mem_dq_oe == 2'b00, "R1 bank drivers off", 64'(mem_dq_oe), 0);
    check(!bus_rdy && !bus_rdata_oe, "R1 bus idle", 64'({bus_rdy, bus_rdata_oe}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(mem_cs_n == 2'b11 && !bus_rdy, "R1 idle after release", 64'({mem_cs_n, bus_rdy}), 6);

    // R2/R6: read preloaded words, every start, varying length and waits.
    for (int a = 0; a < NW; a++) burst(a, a % 8, 1'b0, (a / 8) % 8, a % 3, 0);

    // R6: page break on the final beat, and wrap at the top of memory.
    burst(1, 7, 1'b0, 8, 0, 0);
    burst(58, 6, 1'b0, 3, 2, 0);
    burst(63, 1, 1'b0, 1, 1, 0);

    // R3/R5/R7: writes of every start and length, each read back.
    for (int a = 0; a < NW; a++) begin
      burst(a, (a * 5) % 8, 1'b1, a % 8, a % 4, a + 100);
      burst(a, 7, 1'b0, (a + 3) % 8, (a % 2) * 2, 0);
    end

    // R3: a write whose last beat lands next to a read start.
    burst(31, 1, 1'b1, 1, 3, 999);
    burst(31, 1, 1'b0, 0, 0, 0);

    repeat (4) @(negedge clk);
    // R2: physical placement of every word.
    for (int w = 0; w < NW; w++)
      check(mem[w % 2][w / 2] == expw[w], "R2 word placed by bank bit", 64'(mem[w % 2][w / 2]), 64'(expw[w]));

    summary();
    $finish;
  end

endmodule